// File: doc/BRIEF.md
# Cascadable BCD Up/Down Decade Counter

This block is one decimal digit of a counter. On each rising clock edge it steps its four-bit BCD value up or down, as the direction input selects, provided the active-low count enable is low. Two asynchronous controls act between clock edges. A master reset clears the digit at once. A level-held parallel load drives the digit from a four-bit data input. The reset always wins over the load, and the load always wins over counting.

An active-low terminal-count output marks the last state in the current direction: 9 when counting up and 0 when counting down. It is gated by the enable and decoded with no register in its path. Multi-digit counters are built by wiring each stage's terminal count into the enable of the next stage, with every stage on the same clock. A digit then advances only on the edge where all lower digits roll over.

Top module: `bcd_decade_counter`

## Requirements
- R1: While `mreset` is high, `digit` is 0 at once, without a clock edge, whatever the load, enable, direction and data inputs are.
- R2: While `aload` is high and `mreset` is low, `digit` equals `load_data` without a clock edge, and it follows every change of `load_data`. Clock, enable and direction have no effect during this time.
- R3: When `aload` falls, `digit` keeps the loaded value. That value is the data present at the rising edge of `aload` or at the last clock edge while `aload` was high. Counting then resumes from that value.
- R4: With `aload` low and `count_en_n` high (1 = disabled), `digit` holds its value across clock edges.
- R5: With `aload` low, `count_en_n` low and `up_ndown` high (1 = up), each rising clock edge adds one to `digit`, and 9 wraps to 0.
- R6: With `aload` low, `count_en_n` low and `up_ndown` low (0 = down), each rising clock edge subtracts one from `digit`, and 0 wraps to 9.
- R7: When counting up, `term_cnt_n` is low exactly when `count_en_n` is low and bits 0 and 3 of `digit` are both 1. This means the value 9 among legal codes, and also the codes 11, 13 and 15.
- R8: When counting down, `term_cnt_n` is low exactly when `count_en_n` is low and `digit` is 0.
- R9: `term_cnt_n` responds to changes of `count_en_n` and `up_ndown` in the same cycle, with no clock edge between.
- R10: When a code from 10 to 15 has been loaded, the next up count gives 0 and the next down count gives the code minus one.
- R11: `term_cnt_n` is high whenever `count_en_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge |
| mreset | input | 1 | Asynchronous master clear, active high |
| aload | input | 1 | Asynchronous level-held parallel load, active high |
| load_data | input | 4 | Value applied while loading |
| count_en_n | input | 1 | Count enable, active low |
| up_ndown | input | 1 | Direction: 1 counts up, 0 counts down |
| digit | output | 4 | Current BCD value |
| term_cnt_n | output | 1 | Terminal count, active low, gated by the enable |

## Verification
The counting function is driven through a full up sweep and a full down sweep that each cross the wrap point. A counter that saturates, or that wraps at a binary rather than a decimal boundary, fails one of these sweeps. Loads of illegal codes, counted in both directions, separate a recovery rule based on greater-or-equal from one based on equality. Asynchronous pulses placed between clock edges, and a reset raised on top of an active load, show whether the reset, load and count priority is honoured and whether each control acts without waiting for the clock. Enable and direction are toggled with no clock edge between, which shows that the terminal count is decoded without a register.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } count_dir_e;

   // Value that follows 'cur' in the given direction for a counter of the given radix.
   function automatic logic [7:0] step_value(input logic [7:0] cur, input logic go_up,
                                             input int unsigned radix);
      logic [7:0] top;
      top = 8'(radix - 1);
      if (go_up) return (cur >= top) ? 8'd0 : cur + 8'd1;
      else       return (cur == 8'd0) ? top : cur - 8'd1;
   endfunction
endpackage

// File: rtl/bcd_step.sv
module bcd_step
   import bcd_cnt_pkg::*;
#(
   parameter int unsigned RADIX = 10,
   parameter int unsigned W     = 4
) (
   input  logic [W-1:0] cur,
   input  count_dir_e   dir,
   output logic [W-1:0] nxt
);
   logic [7:0] wide_nxt;

   always_comb begin
      wide_nxt = step_value(8'(cur), dir == DIR_UP, RADIX);
      nxt      = wide_nxt[W-1:0];
   end
endmodule

// File: rtl/bcd_state_reg.sv
module bcd_state_reg #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         mreset,
   input  logic         aload,
   input  logic [W-1:0] load_data,
   input  logic         step_en,
   input  logic [W-1:0] nxt,
   output logic [W-1:0] state
);
   always_ff @(posedge clk or posedge mreset or posedge aload) begin
      if (mreset)       state <= '0;
      else if (aload)   state <= load_data;
      else if (step_en) state <= nxt;
   end
endmodule

// File: rtl/bcd_tc_decode.sv
module bcd_tc_decode
   import bcd_cnt_pkg::*;
#(
   parameter int unsigned RADIX = 10,
   parameter int unsigned W     = 4
) (
   input  logic [W-1:0] value,
   input  logic         count_en_n,
   input  count_dir_e   dir,
   output logic         term_cnt_n
);
   localparam logic [W-1:0] TOP = W'(RADIX - 1);

   logic up_hit;
   logic down_hit;

   generate
      if (RADIX == 10 && W == 4) begin : g_sparse
         // 1001 is the only legal code with both end bits set
         assign up_hit = value[0] & value[3];
      end else begin : g_full
         assign up_hit = (value == TOP);
      end
   endgenerate

   assign down_hit   = (value == '0);
   assign term_cnt_n = ~(~count_en_n & ((dir == DIR_UP) ? up_hit : down_hit));
endmodule

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter
   import bcd_cnt_pkg::*;
#(
   parameter int unsigned RADIX = 10,
   parameter int unsigned W     = 4
) (
   input  logic         clk,
   input  logic         mreset,
   input  logic         aload,
   input  logic [W-1:0] load_data,
   input  logic         count_en_n,
   input  logic         up_ndown,
   output logic [W-1:0] digit,
   output logic         term_cnt_n
);
   generate
      if (RADIX < 2 || RADIX > (1 << W) || W > 8) begin : g_bad_cfg
         $error("bcd_decade_counter: RADIX must lie in 2..2**W and W must not exceed 8");
      end
   endgenerate

   count_dir_e   dir;
   logic [W-1:0] state;
   logic [W-1:0] nxt;

   assign dir = count_dir_e'(up_ndown);

   bcd_step #(.RADIX(RADIX), .W(W)) u_step (
      .cur (state),
      .dir (dir),
      .nxt (nxt)
   );

   bcd_state_reg #(.W(W)) u_reg (
      .clk       (clk),
      .mreset    (mreset),
      .aload     (aload),
      .load_data (load_data),
      .step_en   (~count_en_n),
      .nxt       (nxt),
      .state     (state)
   );

   // Level-transparent view: reset, then load, then stored count
   assign digit = mreset ? '0 : (aload ? load_data : state);

   bcd_tc_decode #(.RADIX(RADIX), .W(W)) u_tc (
      .value      (digit),
      .count_en_n (count_en_n),
      .dir        (dir),
      .term_cnt_n (term_cnt_n)
   );
endmodule

// File: rtl/bcd_decade_counter_chk.sv
module bcd_decade_counter_chk #(
   parameter int unsigned RADIX = 10,
   parameter int unsigned W     = 4
) (
   input logic         clk,
   input logic         mreset,
   input logic         aload,
   input logic         count_en_n,
   input logic         up_ndown,
   input logic [W-1:0] digit,
   input logic         term_cnt_n
);
   localparam logic [W-1:0] TOP = W'(RADIX - 1);

   always @(negedge clk) begin
      if (mreset === 1'b1)
         assert_reset_clears_R1: assert (digit == '0)
            else $error("R1: digit not cleared under reset");
      if (count_en_n === 1'b1)
         assert_tc_idle_when_disabled_R11: assert (term_cnt_n == 1'b1)
            else $error("R11: terminal count active while disabled");
   end

   assert_hold_when_disabled_R4: assert property (@(posedge clk) disable iff (mreset)
      (!aload && count_en_n) |=> (aload || $stable(digit)));

   assert_up_wrap_R5: assert property (@(posedge clk) disable iff (mreset)
      (!aload && !count_en_n && up_ndown && digit == TOP) |=> (aload || digit == '0));

   assert_down_wrap_R6: assert property (@(posedge clk) disable iff (mreset)
      (!aload && !count_en_n && !up_ndown && digit == '0) |=> (aload || digit == TOP));
endmodule

bind bcd_decade_counter bcd_decade_counter_chk #(.RADIX(RADIX), .W(W)) u_chk (
   .clk        (clk),
   .mreset     (mreset),
   .aload      (aload),
   .count_en_n (count_en_n),
   .up_ndown   (up_ndown),
   .digit      (digit),
   .term_cnt_n (term_cnt_n)
);

// File: tb/bcd_decade_counter_bench.sv
`timescale 1ns/1ps
module bcd_decade_counter_bench;
   logic       clk = 1'b0;
   logic       mreset, aload, count_en_n, up_ndown;
   logic [3:0] load_data;
   logic [3:0] digit;
   logic       term_cnt_n;

   int n_checks = 0;
   int n_fails  = 0;

   always #4 clk = ~clk;

   bcd_decade_counter u_bcd_decade_counter (
      .clk(clk), .mreset(mreset), .aload(aload), .load_data(load_data),
      .count_en_n(count_en_n), .up_ndown(up_ndown),
      .digit(digit), .term_cnt_n(term_cnt_n)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic preload(input logic [3:0] v);
      aload = 1'b1; load_data = v; #1;
      tick();
      aload = 1'b0; #1;
   endtask

   task automatic t_reset();
      mreset = 1'b1; aload = 1'b1; load_data = 4'd7; #1;
      chk("R1 reset beats load", digit, 0);
      tick();
      chk("R1 reset holds over edge", digit, 0);
      aload = 1'b0; #1;
      mreset = 1'b0; #1;
      chk("R1 after release", digit, 0);
   endtask

   task automatic t_load();
      count_en_n = 1'b0; up_ndown = 1'b0;
      aload = 1'b1; load_data = 4'd3; #1;
      chk("R2 async load", digit, 3);
      load_data = 4'd8; #1;
      chk("R2 follows data", digit, 8);
      tick();
      chk("R2 clock ignored under load", digit, 8);
      aload = 1'b0; #1;
      chk("R3 value kept on release", digit, 8);
      tick();
      chk("R3 counting resumes", digit, 7);
   endtask

   task automatic t_hold();
      preload(4'd5);
      count_en_n = 1'b1; up_ndown = 1'b1;
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R4 hold when disabled", digit, 5);
      end
      up_ndown = 1'b0;
      tick();
      chk("R4 hold when disabled, down", digit, 5);
   endtask

   task automatic t_up();
      int e;
      preload(4'd0);
      count_en_n = 1'b0; up_ndown = 1'b1; #1;
      e = 0;
      for (int i = 0; i < 12; i++) begin
         chk("R7 up terminal count", term_cnt_n, (e == 9) ? 0 : 1);
         tick();
         e = (e + 1) % 10;
         chk("R5 up count", digit, e);
      end
   endtask

   task automatic t_down();
      int e;
      preload(4'd2);
      count_en_n = 1'b0; up_ndown = 1'b0; #1;
      e = 2;
      for (int i = 0; i < 12; i++) begin
         chk("R8 down terminal count", term_cnt_n, (e == 0) ? 0 : 1);
         tick();
         e = (e == 0) ? 9 : e - 1;
         chk("R6 down count", digit, e);
      end
   endtask

   task automatic t_tc_comb();
      count_en_n = 1'b1;
      preload(4'd9);
      up_ndown = 1'b1; #1;
      chk("R11 disabled at 9", term_cnt_n, 1);
      count_en_n = 1'b0; #1;
      chk("R9 enable without clock", term_cnt_n, 0);
      up_ndown = 1'b0; #1;
      chk("R9 direction without clock", term_cnt_n, 1);
      count_en_n = 1'b1;
      preload(4'd0);
      #1;
      chk("R11 disabled at 0", term_cnt_n, 1);
      count_en_n = 1'b0; #1;
      chk("R8 down terminal at 0", term_cnt_n, 0);
      count_en_n = 1'b1;
   endtask

   task automatic t_illegal();
      count_en_n = 1'b1;
      preload(4'd13);
      count_en_n = 1'b0; up_ndown = 1'b1;
      tick();
      chk("R10 illegal up to zero", digit, 0);
      count_en_n = 1'b1;
      preload(4'd11);
      count_en_n = 1'b0; #1;
      chk("R7 code 11 decodes terminal", term_cnt_n, 0);
      up_ndown = 1'b0; #1;
      count_en_n = 1'b1;
      preload(4'd15);
      count_en_n = 1'b0;
      tick();
      chk("R10 illegal down", digit, 14);
      tick();
      chk("R10 illegal down again", digit, 13);
   endtask

   task automatic t_async_reset_mid_count();
      preload(4'd6);
      count_en_n = 1'b0; up_ndown = 1'b1;
      tick();
      chk("R5 count before reset", digit, 7);
      mreset = 1'b1; #1;
      chk("R1 async reset mid count", digit, 0);
      tick();
      mreset = 1'b0; #1;
      tick();
      chk("R5 count after reset", digit, 1);
   endtask

   initial begin
      #1_000_000;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      mreset = 1'b1; aload = 1'b0; count_en_n = 1'b1; up_ndown = 1'b1; load_data = 4'd0;
      #1;
      chk("R1 reset state", digit, 0);
      chk("R11 reset state terminal", term_cnt_n, 1);
      t_reset();
      t_load();
      t_hold();
      t_up();
      t_down();
      t_tc_comb();
      t_illegal();
      t_async_reset_mid_count();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end
endmodule